// File: doc/BRIEF.md
# Management PHY Register Model

This block models the register side of a single Ethernet PHY as seen through a MAC's management frame register. Software writes a 32-bit frame word that names an operation, a PHY address, a register number and, for writes, 16 data bits. The block performs the access in the same clock edge. For a read, the returned value replaces the low half of the stored frame word. One cycle later it pulses a done event that the MAC's interrupt logic can latch. No serial management timing is modelled.

The model holds control, status, advertisement, interrupt-source and interrupt-mask registers. It also answers the two identifier registers, the link-partner ability register and the expansion register with constants. A link up/down input drives the link and autonegotiation-complete status bits and latches typed interrupt-source bits. Autonegotiation completes as soon as it is requested.

Top module: `mgmt_phy_regs`

## Requirements
- R1: After reset the frame word reads 0 and done is low. Control reads 0x3000, status reads 0x7809, advertisement reads 0x01E1, and interrupt source and mask read 0.
- R2: A control write (register 0) stores only the value bits under mask 0x7980.
- R3: A control write with bit 9 (autonegotiation restart) set sets status bit 5 (0x0020) at the same edge. The bit stays set after later control writes.
- R4: An advertisement write (register 4) stores (value & 0x2D7F) | 0x0080.
- R5: An interrupt-mask write (register 30) keeps value bits 7:0 and reads back with bits 15:8 zero.
- R6: A falling edge on the link input clears status bits 2 and 5 (0x0024) and latches interrupt-source bit 4 (0x0010).
- R7: A rising edge on the link input sets status bits 0x0024 and latches interrupt-source bits 7 and 6 (0x00C0).
- R8: Frame word layout: bit 29 = 1 means read, bits 27:23 are the PHY address and bits 22:18 the register number, bits 15:0 carry write data. After a write the frame word holds the written word unchanged. After a read, bits 31:16 hold the written word's upper half and bits 15:0 hold the register value.
- R9: Every accepted frame write, read or write, gives exactly one done pulse one cycle long, in the cycle after the access. Back-to-back accesses give back-to-back pulses.
- R10: Only PHY address 0 responds. A read of another address or of an unimplemented register number returns 0. Writes to them, and writes to the status register, change nothing.
- R11: Reading interrupt source (register 29) returns its value and clears it. A link edge in the same cycle as the clearing read wins, and its bits remain set.
- R12: Registers 2, 3, 5 and 6 read the constants 0x0022, 0x1513, 0x05E1 and 0x0001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_wr | input | 1 | One-cycle strobe: frame_wdata is a management operation |
| frame_wdata | input | 32 | Management frame word written by software |
| link_up | input | 1 | Link state from the network side, 1 = up |
| frame_rdata | output | 32 | Current content of the frame register |
| mii_done | output | 1 | One-cycle pulse after each completed management access |

## Verification
The bench targets the write masks with all-ones and all-zeros data. A design that stored raw data, or that dropped the forced advertisement bit 7, would read back the wrong value. It starts a link edge in the same cycle as a clearing read of the interrupt-source register. A design that let the clear win would lose the link-up bits on the next read. Accesses to a foreign PHY address, to an unimplemented register number and to the read-only status register must read 0 or leave state untouched. A design that ignored the address field would corrupt the control or mask registers. The scoreboard pairs each access with exactly one done pulse. An extra pulse, a missing pulse or a frame word that lost its upper half is reported.

// File: rtl/mgmt_phy_pkg.sv
// Package: shared constants and the decoded request type for the
// management PHY register model. Assumes a 16-bit PHY register width.
package mgmt_phy_pkg;

    localparam int FRAME_W  = 32;
    localparam int PREG_W   = 16;
    localparam int ADDR_W   = 5;

    // Frame word field positions (decoded by software, fixed)
    localparam int OP_RD_BIT  = 29;
    localparam int PHY_LSB    = 23;
    localparam int REG_LSB    = 18;

    // Register numbers
    localparam logic [ADDR_W-1:0] RN_CTRL  = 5'd0;
    localparam logic [ADDR_W-1:0] RN_STAT  = 5'd1;
    localparam logic [ADDR_W-1:0] RN_IDHI  = 5'd2;
    localparam logic [ADDR_W-1:0] RN_IDLO  = 5'd3;
    localparam logic [ADDR_W-1:0] RN_ADV   = 5'd4;
    localparam logic [ADDR_W-1:0] RN_LPA   = 5'd5;
    localparam logic [ADDR_W-1:0] RN_EXP   = 5'd6;
    localparam logic [ADDR_W-1:0] RN_ISRC  = 5'd29;
    localparam logic [ADDR_W-1:0] RN_IMASK = 5'd30;

    // Reset values and write masks
    localparam logic [PREG_W-1:0] CTRL_RST    = 16'h3000;
    localparam logic [PREG_W-1:0] STAT_RST    = 16'h7809;
    localparam logic [PREG_W-1:0] ADV_RST     = 16'h01E1;
    localparam logic [PREG_W-1:0] CTRL_KEEP   = 16'h7980;
    localparam logic [PREG_W-1:0] CTRL_RESTRT = 16'h0200;
    localparam logic [PREG_W-1:0] ADV_KEEP    = 16'h2D7F;
    localparam logic [PREG_W-1:0] ADV_FORCE   = 16'h0080;
    localparam logic [PREG_W-1:0] ST_ANEG_OK  = 16'h0020;
    localparam logic [PREG_W-1:0] ST_LINK_ALL = 16'h0024;

    localparam int MASK_W = 8;

    // Interrupt-source event bits
    localparam logic [MASK_W-1:0] EV_ENERGY = 8'h80;
    localparam logic [MASK_W-1:0] EV_ANEG   = 8'h40;
    localparam logic [MASK_W-1:0] EV_DOWN   = 8'h10;

    typedef struct packed {
        logic                valid;
        logic                is_read;
        logic                hit;
        logic [ADDR_W-1:0]   regsel;
        logic [PREG_W-1:0]   wdata;
    } mgmt_req_t;

endpackage

// File: rtl/mgmt_frame_decode.sv
// Module: splits a management frame word into a request.
// Assumes the frame strobe is one cycle long; purely combinational.
module mgmt_frame_decode
    import mgmt_phy_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PHY_ADDR = 5'd0
) (
    input  logic                  frame_wr,
    input  logic [FRAME_W-1:0]    frame_wdata,
    output mgmt_req_t             req,
    output logic [FRAME_W-PREG_W-1:0] keep_hi
);

    // Field extraction and address match
    always_comb begin
        req.valid   = frame_wr;
        req.is_read = frame_wdata[OP_RD_BIT];
        req.hit     = (frame_wdata[PHY_LSB +: ADDR_W] == PHY_ADDR);
        req.regsel  = frame_wdata[REG_LSB +: ADDR_W];
        req.wdata   = frame_wdata[PREG_W-1:0];
        keep_hi     = frame_wdata[FRAME_W-1:PREG_W];
    end

endmodule

// File: rtl/mgmt_link_monitor.sv
// Module: edge detector on the link input.
// Assumes link_up is already synchronous to clk. The remembered state
// resets to "down", so a link already up at reset is seen as a rise.
module mgmt_link_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic link_up,
    output logic link_rise,
    output logic link_fall
);

    logic link_q;

    // Remember last sampled link level
    always_ff @(posedge clk) begin
        if (!rst_n) link_q <= 1'b0;
        else        link_q <= link_up;
    end

    // Edge strobes
    assign link_rise =  link_up & ~link_q;
    assign link_fall = ~link_up &  link_q;

endmodule

// File: rtl/mgmt_phy_regfile.sv
// Module: the PHY register set with masked writes, instant
// autonegotiation, link mirroring and read-to-clear interrupt source.
// Assumes one request per cycle; read data is combinational.
module mgmt_phy_regfile
    import mgmt_phy_pkg::*;
#(
    parameter logic [PREG_W-1:0] ID_HI_VAL = 16'h0022,
    parameter logic [PREG_W-1:0] ID_LO_VAL = 16'h1513,
    parameter logic [PREG_W-1:0] LPA_VAL   = 16'h05E1,
    parameter logic [PREG_W-1:0] EXP_VAL   = 16'h0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mgmt_req_t         req,
    input  logic              link_rise,
    input  logic              link_fall,
    output logic [PREG_W-1:0] rdata
);

    logic [PREG_W-1:0] ctrl_q, stat_q, adv_q, stat_nxt;
    logic [MASK_W-1:0] isrc_q, imask_q, isrc_nxt;
    logic              wr_hit, rd_hit;

    assign wr_hit = req.valid & req.hit & ~req.is_read;
    assign rd_hit = req.valid & req.hit &  req.is_read;

    // Control register: masked store
    always_ff @(posedge clk) begin
        if (!rst_n)                                ctrl_q <= CTRL_RST;
        else if (wr_hit && req.regsel == RN_CTRL)  ctrl_q <= req.wdata & CTRL_KEEP;
    end

    // Advertisement register: masked store with forced bit
    always_ff @(posedge clk) begin
        if (!rst_n)                               adv_q <= ADV_RST;
        else if (wr_hit && req.regsel == RN_ADV)  adv_q <= (req.wdata & ADV_KEEP) | ADV_FORCE;
    end

    // Interrupt mask: low byte only
    always_ff @(posedge clk) begin
        if (!rst_n)                                 imask_q <= '0;
        else if (wr_hit && req.regsel == RN_IMASK)  imask_q <= req.wdata[MASK_W-1:0];
    end

    // Status next state: restart completes at once, link edge applied last
    always_comb begin
        stat_nxt = stat_q;
        if (wr_hit && req.regsel == RN_CTRL && (req.wdata & CTRL_RESTRT) != '0)
            stat_nxt = stat_nxt | ST_ANEG_OK;
        if (link_rise) stat_nxt = stat_nxt |  ST_LINK_ALL;
        if (link_fall) stat_nxt = stat_nxt & ~ST_LINK_ALL;
    end

    // Status register
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= STAT_RST;
        else        stat_q <= stat_nxt;
    end

    // Interrupt source next state: read clears, new events win
    always_comb begin
        isrc_nxt = isrc_q;
        if (rd_hit && req.regsel == RN_ISRC) isrc_nxt = '0;
        if (link_rise) isrc_nxt = isrc_nxt | EV_ENERGY | EV_ANEG;
        if (link_fall) isrc_nxt = isrc_nxt | EV_DOWN;
    end

    // Interrupt source register
    always_ff @(posedge clk) begin
        if (!rst_n) isrc_q <= '0;
        else        isrc_q <= isrc_nxt;
    end

    // Read multiplexer; misses return zero
    always_comb begin
        rdata = '0;
        if (req.hit) begin
            case (req.regsel)
                RN_CTRL:  rdata = ctrl_q;
                RN_STAT:  rdata = stat_q;
                RN_IDHI:  rdata = ID_HI_VAL;
                RN_IDLO:  rdata = ID_LO_VAL;
                RN_ADV:   rdata = adv_q;
                RN_LPA:   rdata = LPA_VAL;
                RN_EXP:   rdata = EXP_VAL;
                RN_ISRC:  rdata = {{(PREG_W-MASK_W){1'b0}}, isrc_q};
                RN_IMASK: rdata = {{(PREG_W-MASK_W){1'b0}}, imask_q};
                default:  rdata = '0;
            endcase
        end
    end

    a_r2_ctrl_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~CTRL_KEEP) == '0);

    a_r3_restart_sets_aneg: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && req.regsel == RN_CTRL && req.wdata[9] && !link_fall) |=> stat_q[5]);

    a_r4_adv_shape: assert property (@(posedge clk) disable iff (!rst_n)
        adv_q[7] && ((adv_q & ~(ADV_KEEP | ADV_FORCE)) == '0));

    a_r6_link_down: assert property (@(posedge clk) disable iff (!rst_n)
        link_fall |=> (!stat_q[2] && !stat_q[5] && isrc_q[4]));

    a_r7_link_up: assert property (@(posedge clk) disable iff (!rst_n)
        link_rise |=> (stat_q[2] && stat_q[5] && isrc_q[7] && isrc_q[6]));

    a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && req.regsel == RN_ISRC && !link_rise && !link_fall) |=> (isrc_q == '0));

    a_r10_miss_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (req.valid && !req.hit) |=> ($stable(ctrl_q) && $stable(adv_q) && $stable(imask_q)));

    a_r10_status_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && req.regsel == RN_STAT && !link_rise && !link_fall) |=> $stable(stat_q));

endmodule

// File: rtl/mgmt_phy_regs.sv
// Module: top of the management PHY register model. Holds the frame
// register and the done pulse, and joins decode, link monitor and
// register file. Assumes frame_wr is a single-cycle strobe.
module mgmt_phy_regs
    import mgmt_phy_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PHY_ADDR  = 5'd0,
    parameter logic [PREG_W-1:0] ID_HI_VAL = 16'h0022,
    parameter logic [PREG_W-1:0] ID_LO_VAL = 16'h1513,
    parameter logic [PREG_W-1:0] LPA_VAL   = 16'h05E1,
    parameter logic [PREG_W-1:0] EXP_VAL   = 16'h0001
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_wr,
    input  logic [FRAME_W-1:0] frame_wdata,
    input  logic               link_up,
    output logic [FRAME_W-1:0] frame_rdata,
    output logic               mii_done
);

    mgmt_req_t                  req;
    logic [FRAME_W-PREG_W-1:0]  keep_hi;
    logic [PREG_W-1:0]          reg_rdata;
    logic                       link_rise, link_fall;
    logic [FRAME_W-1:0]         frame_q;
    logic                       done_q;

    mgmt_frame_decode #(.PHY_ADDR(PHY_ADDR)) u_dec (
        .frame_wr    (frame_wr),
        .frame_wdata (frame_wdata),
        .req         (req),
        .keep_hi     (keep_hi)
    );

    mgmt_link_monitor u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_up   (link_up),
        .link_rise (link_rise),
        .link_fall (link_fall)
    );

    mgmt_phy_regfile #(
        .ID_HI_VAL (ID_HI_VAL),
        .ID_LO_VAL (ID_LO_VAL),
        .LPA_VAL   (LPA_VAL),
        .EXP_VAL   (EXP_VAL)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .link_rise (link_rise),
        .link_fall (link_fall),
        .rdata     (reg_rdata)
    );

    // Frame register: store word, splice in read data on reads
    always_ff @(posedge clk) begin
        if (!rst_n)
            frame_q <= '0;
        else if (req.valid)
            frame_q <= req.is_read ? {keep_hi, reg_rdata} : {keep_hi, req.wdata};
    end

    // Completion event one cycle after each access
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= req.valid;
    end

    assign frame_rdata = frame_q;
    assign mii_done    = done_q;

    a_r9_done_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        frame_wr |=> mii_done);

    a_r9_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_wr |=> !mii_done);

    a_r8_upper_half_kept: assert property (@(posedge clk) disable iff (!rst_n)
        frame_wr |=> (frame_rdata[31:16] == $past(frame_wdata[31:16])));

endmodule

// File: tb/mgmt_phy_regs_bench.sv
// Scoreboard bench: driver tasks queue the expected frame word per access,
// a monitor pops one entry per done pulse and compares.
module mgmt_phy_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_wr = 1'b0;
    logic [31:0] frame_wdata = '0;
    logic        link_up = 1'b0;
    logic [31:0] frame_rdata;
    logic        mii_done;

    int n_run  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    mgmt_phy_regs u_mgmt_phy_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_wr    (frame_wr),
        .frame_wdata (frame_wdata),
        .link_up     (link_up),
        .frame_rdata (frame_rdata),
        .mii_done    (mii_done)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit rd, input logic [4:0] phy,
                                       input logic [4:0] rn, input logic [15:0] d);
        return {1'b1, 1'b0, rd, 1'b0, phy, rn, 2'b11, d};
    endfunction

    // Called at a falling edge; issues one access and queues its expectation
    task automatic access(input logic [31:0] w, input logic [31:0] exp, input string tag);
        frame_wr    = 1'b1;
        frame_wdata = w;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        frame_wr    = 1'b0;
    endtask

    task automatic rd(input logic [4:0] phy, input logic [4:0] rn,
                      input logic [15:0] val, input string tag);
        logic [31:0] w;
        w = mk(1'b1, phy, rn, 16'hDEAD);
        access(w, {w[31:16], val}, tag);
    endtask

    task automatic wr(input logic [4:0] phy, input logic [4:0] rn,
                      input logic [15:0] d, input string tag);
        logic [31:0] w;
        w = mk(1'b0, phy, rn, d);
        access(w, w, tag);
    endtask

    // Monitor: one queued expectation per done pulse
    always @(negedge clk) begin
        if (rst_n && mii_done && !ended) begin
            if (exp_q.size() == 0) begin
                n_run++; n_fail++;
                $display("FAIL R9: actual done pulse expected none");
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, frame_rdata, e);
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check("R1 frame after reset", frame_rdata, 32'h0);
        check("R1 done after reset", {31'b0, mii_done}, 32'h0);

        rd(0, 0, 16'h3000, "R1 control reset");
        rd(0, 1, 16'h7809, "R1 status reset");
        rd(0, 4, 16'h01E1, "R1 advert reset");
        rd(0, 29, 16'h0000, "R1 source reset");
        rd(0, 30, 16'h0000, "R1 mask reset");

        rd(0, 2, 16'h0022, "R12 id high");
        rd(0, 3, 16'h1513, "R12 id low");
        rd(0, 5, 16'h05E1, "R12 partner ability");
        rd(0, 6, 16'h0001, "R12 expansion");

        wr(0, 0, 16'hFFFF, "R8 write frame kept");
        rd(0, 0, 16'h7980, "R2 control mask");
        rd(0, 1, 16'h7829, "R3 restart sets aneg");
        wr(0, 0, 16'h0000, "R8 write frame kept");
        rd(0, 0, 16'h0000, "R2 control cleared");
        rd(0, 1, 16'h7829, "R3 aneg bit stays");

        wr(0, 4, 16'hFFFF, "R8 write frame kept");
        rd(0, 4, 16'h2DFF, "R4 advert all ones");
        wr(0, 4, 16'h0000, "R8 write frame kept");
        rd(0, 4, 16'h0080, "R4 advert forced bit");

        wr(0, 30, 16'hABCD, "R8 write frame kept");
        rd(0, 30, 16'h00CD, "R5 mask low byte");

        link_up = 1'b1;
        repeat (2) @(negedge clk);
        rd(0, 1, 16'h782D, "R7 status link up");
        rd(0, 29, 16'h00C0, "R7 source link up");
        rd(0, 29, 16'h0000, "R11 source cleared");

        link_up = 1'b0;
        repeat (2) @(negedge clk);
        rd(0, 1, 16'h7809, "R6 status link down");
        rd(0, 29, 16'h0010, "R6 source link down");
        rd(0, 29, 16'h0000, "R11 source cleared");

        wr(0, 1, 16'hFFFF, "R8 write frame kept");
        rd(0, 1, 16'h7809, "R10 status read only");
        rd(1, 0, 16'h0000, "R10 foreign phy read");
        wr(3, 30, 16'h0011, "R8 write frame kept");
        rd(0, 30, 16'h00CD, "R10 foreign phy write ignored");
        wr(0, 7, 16'h1234, "R8 write frame kept");
        rd(0, 7, 16'h0000, "R10 unimplemented read");
        wr(2, 0, 16'hFFFF, "R8 write frame kept");
        rd(0, 0, 16'h0000, "R10 foreign control ignored");

        link_up = 1'b1;
        rd(0, 29, 16'h0000, "R11 read with link edge");
        rd(0, 29, 16'h00C0, "R11 link edge wins over clear");

        repeat (3) @(negedge clk);
        check("R9 done idle low", {31'b0, mii_done}, 32'h0);
        check("R9 every access completed", exp_q.size(), 32'h0);

        ended = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule